// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block supplies the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). There are four pipeline registers between the stages: IF/ID, ID/EX, EX/MEM and MEM/WB. The block looks at the source register numbers of the instructions in decode and execute. It also looks at the destination numbers, write enables and load flags of the instructions in execute, memory and writeback. From these it derives three kinds of output: operand bypass selects for the execute stage, bypass selects for the branch comparator in decode, and hold and bubble strobes for the front of the pipe.

Branch and jump decisions are resolved in decode, and completed results are bypassed back into decode. A branch that depends on the ALU result of the instruction just ahead of it therefore waits one cycle. A branch that depends on a load waits until the loaded value reaches writeback. A redirect from decode squashes the single younger instruction already fetched. When a flush or bubble is requested, the surrounding datapath loads the pipeline register with its write and memory enables cleared.

The decision logic is combinational, so every output follows its inputs in the same cycle. The clock and reset inputs are used only by the block's clocked self-checks.

Top module: `hazard_unit`

## Requirements
- R1: The execute operand selects `exFwdA`/`exFwdB` take 2 (EX/MEM result) when the memory-stage instruction writes the operand's register, otherwise 1 (MEM/WB result) when the writeback instruction writes it, otherwise 0 (register file). A stage whose write enable is low is never a source.
- R2: Register x0 is never a bypass source and never causes a stall, even when every stage reports a write to x0.
- R3: When the memory and writeback stages both write the register that an execute operand reads, the select is 2 (the younger, memory-stage value).
- R4: A load in execute whose destination equals a used decode source causes a stall. A stall raises `pcHold`, `ifIdHold` and `idExFlush` (a bubble into ID/EX) and keeps `ifIdFlush` and `pcTakeTarget` low.
- R5: A compare-using instruction in decode (`idCmpUse`=1) whose used source is written by a non-load instruction in execute stalls. When that producer has moved to memory, the decode select is 2 and there is no stall.
- R6: A compare-using decode instruction whose source is written by a load stalls while the load is in execute and while it is in memory. When the load reaches writeback, the decode select is 1 and there is no stall.
- R7: The decode selects `idFwdA`/`idFwdB` use the encoding 0 = register file, 1 = MEM/WB, 2 = EX/MEM. A non-load memory-stage writer takes priority over a writeback writer.
- R8: A redirect request with no stall raises `ifIdFlush` and `pcTakeTarget`, with no hold and no ID/EX bubble.
- R9: When a redirect request coincides with a stall, the stall wins: hold and bubble are raised and the redirect strobes stay low.
- R10: With no dependency, all selects are 0 and all control strobes are low. A source whose used flag is low never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock (used by the self-checks only) |
| rstN | input | 1 | Active-low reset (used by the self-checks only) |
| idRs1 | input | 5 | Decode-stage first source register |
| idRs2 | input | 5 | Decode-stage second source register |
| idRs1Used | input | 1 | Decode instruction reads its first source |
| idRs2Used | input | 1 | Decode instruction reads its second source |
| idCmpUse | input | 1 | Decode instruction compares or jumps in decode |
| exRs1 | input | 5 | Execute-stage first source register |
| exRs2 | input | 5 | Execute-stage second source register |
| exRd | input | 5 | Execute-stage destination register |
| exRegWrite | input | 1 | Execute-stage instruction writes a register |
| exIsLoad | input | 1 | Execute-stage instruction is a load |
| memRd | input | 5 | Memory-stage destination register |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| memIsLoad | input | 1 | Memory-stage instruction is a load |
| wbRd | input | 5 | Writeback-stage destination register |
| wbRegWrite | input | 1 | Writeback-stage instruction writes a register |
| redirectReq | input | 1 | Decode resolved a taken branch or jump |
| exFwdA | output | 2 | Execute first operand select |
| exFwdB | output | 2 | Execute second operand select |
| idFwdA | output | 2 | Decode comparator first operand select |
| idFwdB | output | 2 | Decode comparator second operand select |
| pcHold | output | 1 | Keep the PC |
| ifIdHold | output | 1 | Keep IF/ID |
| ifIdFlush | output | 1 | Turn IF/ID into a bubble |
| idExFlush | output | 1 | Turn ID/EX into a bubble |
| pcTakeTarget | output | 1 | PC loads the redirect target |

## Verification
The clocked checks cover several rules on every cycle. Execute operands that read x0 select the register file. The memory-stage writer wins over the writeback writer. A load-use or execute-stage branch dependency always raises the hold. A stall always comes with a bubble. A redirect flushes the front of the pipe exactly when no stall is active. The scenarios exercise what no single-cycle rule captures: the multi-cycle branch-after-load sequence as the load walks from execute to writeback, the handover from a stall to bypassing once the producer moves on, and the fact that an unused source or a disabled write never disturbs the pipe.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int NSRC = 4;  // idRs1, idRs2, exRs1, exRs2
  localparam int SRC_ID1 = 0;
  localparam int SRC_ID2 = 1;
  localparam int SRC_EX1 = 2;
  localparam int SRC_EX2 = 3;

  typedef enum logic [1:0] {
    SEL_REGFILE = 2'd0,
    SEL_WB      = 2'd1,
    SEL_MEM     = 2'd2
  } fwdSel_e;

  // Strobes from the compare datapath to the control
  typedef struct packed {
    logic [NSRC-1:0] atEx;
    logic [NSRC-1:0] atMem;
    logic [NSRC-1:0] atWb;
  } hzMatch_t;
endpackage

// File: rtl/hazard_compare.sv
module hazard_compare
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [NSRC-1:0][REG_AW-1:0] srcRegs,
  input  logic [REG_AW-1:0]           exRd,
  input  logic                        exRegWrite,
  input  logic [REG_AW-1:0]           memRd,
  input  logic                        memRegWrite,
  input  logic [REG_AW-1:0]           wbRd,
  input  logic                        wbRegWrite,
  output hzMatch_t                    match
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic exLive, memLive, wbLive;
  assign exLive  = exRegWrite  && (exRd  != ZERO_REG);
  assign memLive = memRegWrite && (memRd != ZERO_REG);
  assign wbLive  = wbRegWrite  && (wbRd  != ZERO_REG);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign match.atEx[s]  = exLive  && (srcRegs[s] == exRd);
    assign match.atMem[s] = memLive && (srcRegs[s] == memRd);
    assign match.atWb[s]  = wbLive  && (srcRegs[s] == wbRd);
  end
endmodule

// File: rtl/hazard_control.sv
module hazard_control
  import hazard_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  hzMatch_t match,
  input  logic     idRs1Used,
  input  logic     idRs2Used,
  input  logic     idCmpUse,
  input  logic     exIsLoad,
  input  logic     memIsLoad,
  input  logic     redirectReq,
  output logic [1:0] exFwdA,
  output logic [1:0] exFwdB,
  output logic [1:0] idFwdA,
  output logic [1:0] idFwdB,
  output logic     pcHold,
  output logic     ifIdHold,
  output logic     ifIdFlush,
  output logic     idExFlush,
  output logic     pcTakeTarget
);
  function automatic fwdSel_e pickEx(input logic atMem, input logic atWb);
    if (atMem)     return SEL_MEM;
    else if (atWb) return SEL_WB;
    else           return SEL_REGFILE;
  endfunction

  // A load in memory has no data yet; decode must wait for it
  function automatic fwdSel_e pickId(input logic atMem, input logic atWb,
                                     input logic memLoad);
    if (atMem && !memLoad) return SEL_MEM;
    else if (atWb)         return SEL_WB;
    else                   return SEL_REGFILE;
  endfunction

  logic depEx, depMemLoad, loadUse, branchWait, stall;

  always_comb begin
    exFwdA = pickEx(match.atMem[SRC_EX1], match.atWb[SRC_EX1]);
    exFwdB = pickEx(match.atMem[SRC_EX2], match.atWb[SRC_EX2]);
    idFwdA = pickId(match.atMem[SRC_ID1], match.atWb[SRC_ID1], memIsLoad);
    idFwdB = pickId(match.atMem[SRC_ID2], match.atWb[SRC_ID2], memIsLoad);
  end

  assign depEx      = (idRs1Used && match.atEx[SRC_ID1]) ||
                      (idRs2Used && match.atEx[SRC_ID2]);
  assign depMemLoad = memIsLoad &&
                      ((idRs1Used && match.atMem[SRC_ID1]) ||
                       (idRs2Used && match.atMem[SRC_ID2]));
  assign loadUse    = exIsLoad && depEx;
  assign branchWait = idCmpUse && (depEx || depMemLoad);
  assign stall      = loadUse || branchWait;

  assign pcHold       = stall;
  assign ifIdHold     = stall;
  assign idExFlush    = stall;
  assign ifIdFlush    = redirectReq && !stall;
  assign pcTakeTarget = redirectReq && !stall;

  // R6: a compare waiting on a load still in memory must hold
  p_load_mem_branch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (idCmpUse && memIsLoad && idRs1Used && match.atMem[SRC_ID1]) |-> pcHold);

  // R6: decode never takes a select of 2 from a load
  p_no_mem_load_fwd_r6: assert property (@(posedge clk) disable iff (!rstN)
    memIsLoad |-> (idFwdA != SEL_MEM && idFwdB != SEL_MEM));
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] idRs1,
  input  logic [REG_AW-1:0] idRs2,
  input  logic              idRs1Used,
  input  logic              idRs2Used,
  input  logic              idCmpUse,
  input  logic [REG_AW-1:0] exRs1,
  input  logic [REG_AW-1:0] exRs2,
  input  logic [REG_AW-1:0] exRd,
  input  logic              exRegWrite,
  input  logic              exIsLoad,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memRegWrite,
  input  logic              memIsLoad,
  input  logic [REG_AW-1:0] wbRd,
  input  logic              wbRegWrite,
  input  logic              redirectReq,
  output logic [1:0]        exFwdA,
  output logic [1:0]        exFwdB,
  output logic [1:0]        idFwdA,
  output logic [1:0]        idFwdB,
  output logic              pcHold,
  output logic              ifIdHold,
  output logic              ifIdFlush,
  output logic              idExFlush,
  output logic              pcTakeTarget
);
  logic [NSRC-1:0][REG_AW-1:0] srcRegs;
  hzMatch_t match;

  assign srcRegs[SRC_ID1] = idRs1;
  assign srcRegs[SRC_ID2] = idRs2;
  assign srcRegs[SRC_EX1] = exRs1;
  assign srcRegs[SRC_EX2] = exRs2;

  hazard_compare #(.REG_AW(REG_AW)) u_compare (
    .srcRegs(srcRegs), .exRd(exRd), .exRegWrite(exRegWrite),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite), .match(match)
  );

  hazard_control u_control (
    .clk(clk), .rstN(rstN), .match(match),
    .idRs1Used(idRs1Used), .idRs2Used(idRs2Used), .idCmpUse(idCmpUse),
    .exIsLoad(exIsLoad), .memIsLoad(memIsLoad), .redirectReq(redirectReq),
    .exFwdA(exFwdA), .exFwdB(exFwdB), .idFwdA(idFwdA), .idFwdB(idFwdB),
    .pcHold(pcHold), .ifIdHold(ifIdHold), .ifIdFlush(ifIdFlush),
    .idExFlush(idExFlush), .pcTakeTarget(pcTakeTarget)
  );

  p_x0_regfile_r2: assert property (@(posedge clk) disable iff (!rstN)
    (exRs1 == '0) |-> (exFwdA == 2'd0));

  p_mem_over_wb_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memRegWrite && wbRegWrite && memRd == wbRd && memRd == exRs2 && memRd != '0)
    |-> (exFwdB == 2'd2));

  p_load_use_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (exIsLoad && exRegWrite && exRd != '0 && idRs1Used && exRd == idRs1) |-> pcHold);

  p_hold_bubble_r4: assert property (@(posedge clk) disable iff (!rstN)
    pcHold |-> (ifIdHold && idExFlush));

  p_branch_ex_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    (idCmpUse && idRs2Used && exRegWrite && exRd != '0 && exRd == idRs2) |-> pcHold);

  p_redirect_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    (redirectReq && !pcHold) |-> (ifIdFlush && pcTakeTarget));

  p_stall_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (redirectReq && pcHold) |-> (!ifIdFlush && !pcTakeTarget));
endmodule

// File: tb/tb_hazard_unit.sv
module tb_hazard_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic idRs1Used, idRs2Used, idCmpUse, exRegWrite, exIsLoad;
  logic memRegWrite, memIsLoad, wbRegWrite, redirectReq;
  logic [1:0] exFwdA, exFwdB, idFwdA, idFwdB;
  logic pcHold, ifIdHold, ifIdFlush, idExFlush, pcTakeTarget;

  hazard_unit dut (.*);

  typedef struct packed {
    logic [4:0] ir1; logic [4:0] ir2; logic u1; logic u2; logic cmp;
    logic [4:0] er1; logic [4:0] er2; logic [4:0] erd; logic ew; logic el;
    logic [4:0] mrd; logic mw; logic ml;
    logic [4:0] wrd; logic ww; logic redir;
    logic [1:0] eA; logic [1:0] eB; logic [1:0] iA; logic [1:0] iB;
    logic [4:0] ctl;  // {pcHold, ifIdHold, ifIdFlush, idExFlush, pcTakeTarget}
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R10 no dependency
    '{5'd1,5'd2,1'b1,1'b1,1'b0, 5'd3,5'd4,5'd5,1'b1,1'b0, 5'd6,1'b1,1'b0, 5'd7,1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0, 5'b00000, 4'd10},
    // R1 A from MEM, B from WB
    '{5'd2,5'd3,1'b1,1'b1,1'b0, 5'd5,5'd6,5'd1,1'b1,1'b0, 5'd5,1'b1,1'b0, 5'd6,1'b1,1'b0, 2'd2,2'd1,2'd0,2'd0, 5'b00000, 4'd1},
    // R3 both stages write the same register
    '{5'd9,5'd10,1'b1,1'b1,1'b0, 5'd8,5'd8,5'd1,1'b1,1'b0, 5'd8,1'b1,1'b0, 5'd8,1'b1,1'b0, 2'd2,2'd2,2'd0,2'd0, 5'b00000, 4'd3},
    // R2 everything targets x0
    '{5'd0,5'd0,1'b1,1'b1,1'b1, 5'd0,5'd0,5'd0,1'b1,1'b1, 5'd0,1'b1,1'b0, 5'd0,1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0, 5'b00000, 4'd2},
    // R1 write enables low
    '{5'd1,5'd2,1'b1,1'b1,1'b0, 5'd8,5'd9,5'd5,1'b1,1'b0, 5'd8,1'b0,1'b0, 5'd9,1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0, 5'b00000, 4'd1},
    // R4 load-use
    '{5'd4,5'd2,1'b1,1'b1,1'b0, 5'd1,5'd2,5'd4,1'b1,1'b1, 5'd10,1'b1,1'b0, 5'd11,1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0, 5'b11010, 4'd4},
    // R10 matching source not used
    '{5'd3,5'd4,1'b1,1'b0,1'b0, 5'd1,5'd2,5'd4,1'b1,1'b1, 5'd10,1'b1,1'b0, 5'd11,1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0, 5'b00000, 4'd10},
    // R5 compare on execute ALU result
    '{5'd12,5'd2,1'b1,1'b1,1'b1, 5'd3,5'd4,5'd12,1'b1,1'b0, 5'd6,1'b1,1'b0, 5'd7,1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0, 5'b11010, 4'd5},
    // R5 producer moved to memory
    '{5'd12,5'd2,1'b1,1'b1,1'b1, 5'd3,5'd4,5'd20,1'b1,1'b0, 5'd12,1'b1,1'b0, 5'd7,1'b1,1'b0, 2'd0,2'd0,2'd2,2'd0, 5'b00000, 4'd5},
    // R6 load in execute
    '{5'd1,5'd13,1'b1,1'b1,1'b1, 5'd3,5'd4,5'd13,1'b1,1'b1, 5'd6,1'b1,1'b0, 5'd7,1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0, 5'b11010, 4'd6},
    // R6 load in memory
    '{5'd1,5'd13,1'b1,1'b1,1'b1, 5'd3,5'd4,5'd0,1'b0,1'b0, 5'd13,1'b1,1'b1, 5'd7,1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0, 5'b11010, 4'd6},
    // R6 load in writeback
    '{5'd1,5'd13,1'b1,1'b1,1'b1, 5'd3,5'd4,5'd0,1'b0,1'b0, 5'd21,1'b1,1'b0, 5'd13,1'b1,1'b0, 2'd0,2'd0,2'd0,2'd1, 5'b00000, 4'd6},
    // R7 decode memory over writeback
    '{5'd14,5'd2,1'b1,1'b1,1'b1, 5'd3,5'd4,5'd5,1'b1,1'b0, 5'd14,1'b1,1'b0, 5'd14,1'b1,1'b0, 2'd0,2'd0,2'd2,2'd0, 5'b00000, 4'd7},
    // R8 clean redirect
    '{5'd1,5'd2,1'b1,1'b1,1'b1, 5'd3,5'd4,5'd5,1'b1,1'b0, 5'd6,1'b1,1'b0, 5'd7,1'b1,1'b1, 2'd0,2'd0,2'd0,2'd0, 5'b00101, 4'd8},
    // R9 redirect during branch stall
    '{5'd12,5'd2,1'b1,1'b1,1'b1, 5'd3,5'd4,5'd12,1'b1,1'b0, 5'd6,1'b1,1'b0, 5'd7,1'b1,1'b1, 2'd0,2'd0,2'd0,2'd0, 5'b11010, 4'd9},
    // R9 redirect during load-use stall
    '{5'd4,5'd2,1'b1,1'b1,1'b0, 5'd3,5'd5,5'd4,1'b1,1'b1, 5'd6,1'b1,1'b0, 5'd7,1'b1,1'b1, 2'd0,2'd0,2'd0,2'd0, 5'b11010, 4'd9}
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [12:0] outVec();
    return {exFwdA, exFwdB, idFwdA, idFwdB,
            pcHold, ifIdHold, ifIdFlush, idExFlush, pcTakeTarget};
  endfunction

  task automatic check(input string tag, input logic [12:0] exp);
    checks++;
    if (outVec() !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, outVec(), exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    idRs1 = v.ir1; idRs2 = v.ir2; idRs1Used = v.u1; idRs2Used = v.u2;
    idCmpUse = v.cmp; exRs1 = v.er1; exRs2 = v.er2; exRd = v.erd;
    exRegWrite = v.ew; exIsLoad = v.el; memRd = v.mrd; memRegWrite = v.mw;
    memIsLoad = v.ml; wbRd = v.wrd; wbRegWrite = v.ww; redirectReq = v.redir;
    #2;
  endtask

  initial begin
    apply('0);
    check("R10 reset idle", 13'd0);
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {VECS[i].eA, VECS[i].eB, VECS[i].iA, VECS[i].iB, VECS[i].ctl});
    end

    // R6 sequence: load walks from execute to writeback under a compare
    apply('{5'd1,5'd17,1'b1,1'b1,1'b1, 5'd3,5'd4,5'd17,1'b1,1'b1, 5'd6,1'b1,1'b0,
            5'd7,1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0, 5'b0, 4'd6});
    check("R6 seq load in EX", 13'b00_00_00_00_11010);
    apply('{5'd1,5'd17,1'b1,1'b1,1'b1, 5'd3,5'd4,5'd0,1'b0,1'b0, 5'd17,1'b1,1'b1,
            5'd6,1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0, 5'b0, 4'd6});
    check("R6 seq load in MEM", 13'b00_00_00_00_11010);
    apply('{5'd1,5'd17,1'b1,1'b1,1'b1, 5'd3,5'd4,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0,
            5'd17,1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0, 5'b0, 4'd6});
    check("R6 seq load in WB", 13'b00_00_00_01_00000);

    // R2 x0 as a load destination under a compare in decode
    apply('{5'd0,5'd0,1'b1,1'b1,1'b1, 5'd0,5'd0,5'd0,1'b1,1'b1, 5'd0,1'b1,1'b1,
            5'd0,1'b1,1'b1, 2'd0,2'd0,2'd0,2'd0, 5'b0, 4'd2});
    check("R2 x0 load no stall", 13'b00_00_00_00_00101);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (10000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule